// File: doc/BRIEF.md
# Delay Line on Two Single-Port Banks

This block is a word-wide delay line of fixed length `DEPTH`. Each clock cycle in which `shift_i` is high, it takes in one word. On that same edge it presents, on `data_o`, the word that came in `DEPTH` enabled shifts earlier. From outside it behaves like a circular buffer kept in a dual-port memory. Inside, the storage is two single-port banks of `DEPTH/2` words each. Each bank performs exactly one read or one write per cycle.

Words go alternately into bank 0 and bank 1. In any enabled cycle, one bank is written and the other bank is read. The read fetches the word that is due to leave on the next enabled shift. That word is held in the bank's read register and moves into the output register on the next enabled shift. When `shift_i` is low, no bank is touched and every visible output holds its value. `DEPTH` must be even.

Top module: `sp_delay_line`

## Requirements
- R1: While `rst_ni` is low and right after it is released, `valid_o` is 0 and `data_o` is all zeros.
- R2: On the edge of enabled shift number k (counted from 0 after reset), `data_o` takes the word presented at enabled shift k-`DEPTH`, for every k ≥ `DEPTH`.
- R3: `valid_o` goes to 1 on the edge of enabled shift number `DEPTH` (the `DEPTH`+1-th shift after reset). It stays 1 until the next reset.
- R4: On a cycle with `shift_i` low, `data_o` and `valid_o` keep their values, no bank is accessed, and the cycle does not count toward the delay.
- R5: In each enabled cycle exactly one bank is written and the other is read. No bank sees more than one access per cycle, and a bank's read register changes only on a read.
- R6: The written bank alternates on every enabled shift, starting with bank 0. The shared address advances after each write to bank 1 and wraps from `DEPTH/2`-1 to 0.
- R7: A reset in the middle of operation restarts the fill. After it, `valid_o` is again low until the `DEPTH`+1-th enabled shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_i | input | 1 | Shift enable: take in `data_i` and advance the line |
| data_i | input | DATA_W | Word entering the line |
| data_o | output | DATA_W | Word that entered `DEPTH` enabled shifts earlier |
| valid_o | output | 1 | High once `data_o` holds a real delayed word |

## Verification
The bench builds two instances side by side and feeds both the same stimulus. One has `DEPTH` = 8, so each bank is four words deep and the address counter wraps many times during the run. The other has `DEPTH` = 2, so each bank holds a single word. That second instance reaches the degenerate case in which the address never moves and the written location is the one just read. An irregular enable pattern stalls the line at every phase of the bank toggle. A reset in mid-stream shows that the fill tracking restarts.

// File: rtl/sp_dl_pkg.sv
package sp_dl_pkg;

  // Address width of one bank; at least one bit even for a single-word bank.
  function automatic int addr_width(input int words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction

  function automatic int count_width(input int limit);
    return (limit > 0) ? $clog2(limit + 1) : 1;
  endfunction

endpackage

// File: rtl/sp_dl_ram.sv
module sp_dl_ram #(
  parameter int DATA_W = 8,
  parameter int WORDS  = 4,
  parameter int AW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem_q[addr_i] <= wdata_i;
  end

  // Read register only moves on a read; writes leave it alone.
  always_ff @(posedge clk_i) begin
    if (en_i && !we_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;

  AST_RAM_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (int'(addr_i) < WORDS)) else $error("bank address out of range"); // R6

  AST_RAM_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || we_i) |=> $stable(rdata_o)) else $error("read register moved without read"); // R5

endmodule

// File: rtl/sp_dl_addr_gen.sv
module sp_dl_addr_gen #(
  parameter int WORDS = 4,
  parameter int AW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  output logic          bank_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o
);

  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic          bank_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_nxt;

  assign addr_nxt = (addr_q == LAST) ? '0 : addr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b0;
      addr_q <= '0;
    end else if (shift_i) begin
      bank_q <= ~bank_q;
      if (bank_q) addr_q <= addr_nxt;
    end
  end

  // Other bank holds the next outgoing word: same row when writing bank 0, next row when writing bank 1.
  assign bank_o    = bank_q;
  assign wr_addr_o = addr_q;
  assign rd_addr_o = bank_q ? addr_nxt : addr_q;

  AST_BANK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (bank_o != $past(bank_o))) else $error("bank did not toggle"); // R6

  AST_ADDR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> ($stable(wr_addr_o) && $stable(bank_o))) else $error("counters moved while idle"); // R4

  AST_ADDR_EVEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !bank_o) |=> $stable(wr_addr_o)) else $error("address moved after bank 0 write"); // R6

endmodule

// File: rtl/sp_dl_fill.sv
module sp_dl_fill #(
  parameter int DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  output logic valid_o
);

  localparam int CW = sp_dl_pkg::count_width(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (shift_i) begin
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      else               valid_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o) else $error("valid dropped"); // R3

  AST_VALID_NEEDS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(shift_i)) else $error("valid rose without shift"); // R4

endmodule

// File: rtl/sp_delay_line.sv
module sp_delay_line #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  localparam int HALF = DEPTH / 2;
  localparam int AW   = sp_dl_pkg::addr_width(HALF);

  logic              bank_sel;
  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     rd_addr;
  logic [1:0]        bank_we;
  logic [DATA_W-1:0] bank_rdata [2];
  logic [DATA_W-1:0] out_q;

  sp_dl_addr_gen #(.WORDS(HALF), .AW(AW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift_i),
    .bank_o    (bank_sel),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [AW-1:0] addr;
    assign bank_we[b] = (bank_sel == 1'(b));
    assign addr       = bank_we[b] ? wr_addr : rd_addr;

    sp_dl_ram #(.DATA_W(DATA_W), .WORDS(HALF), .AW(AW)) u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (shift_i),
      .we_i    (bank_we[b]),
      .addr_i  (addr),
      .wdata_i (data_i),
      .rdata_o (bank_rdata[b])
    );
  end

  // Bank being written now was read on the previous shift: that word leaves now.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_q <= '0;
    else if (shift_i) out_q <= bank_rdata[bank_sel];
  end

  assign data_o = out_q;

  sp_dl_fill #(.DEPTH(DEPTH)) u_fill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_i),
    .valid_o (valid_o)
  );

  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> ($countones(bank_we) == 1)) else $error("not exactly one bank written"); // R5

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> ($stable(data_o) && $stable(valid_o))) else $error("output moved while idle"); // R4

endmodule

// File: tb/sp_delay_line_tb.sv
`timescale 1ns/1ps
module sp_delay_line_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       shift = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout8, dout2;
  logic       val8, val2;

  int tests = 0;
  int fails = 0;
  int shifts = 0;
  logic [7:0] q8[$];
  logic [7:0] q2[$];
  logic [7:0] last8 = '0, last2 = '0;
  logic       lastv8 = 1'b0, lastv2 = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  sp_delay_line #(.DATA_W(8), .DEPTH(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .shift_i(shift), .data_i(din),
    .data_o(dout8), .valid_o(val8));

  sp_delay_line #(.DATA_W(8), .DEPTH(2)) u_dut_d2 (
    .clk_i(clk), .rst_ni(rst_ni), .shift_i(shift), .data_i(din),
    .data_o(dout2), .valid_o(val2));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    shift  = 1'b0;
    @(posedge clk); #2;
    chk("R1 R7 valid d8 in reset", {7'd0, val8}, 8'd0);
    chk("R1 R7 valid d2 in reset", {7'd0, val2}, 8'd0);
    chk("R1 data d8 in reset", dout8, 8'd0);
    chk("R1 data d2 in reset", dout2, 8'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    q8.delete(); q2.delete();
    shifts = 0;
    last8 = '0; last2 = '0; lastv8 = 1'b0; lastv2 = 1'b0;
  endtask

  // Driver pushes the word; monitor side pops the expected word after the edge.
  task automatic step(input bit en, input logic [7:0] d);
    logic [7:0] e;
    @(negedge clk);
    shift = en;
    din   = d;
    if (en) begin
      q8.push_back(d);
      q2.push_back(d);
      shifts++;
    end
    @(posedge clk); #2;
    chk("R3 R7 valid d8", {7'd0, val8}, {7'd0, (shifts > 8)});
    chk("R3 R7 valid d2", {7'd0, val2}, {7'd0, (shifts > 2)});
    if (en) begin
      if (q8.size() > 8) begin
        e = q8.pop_front();
        chk("R2 R5 R6 data d8", dout8, e);
      end
      if (q2.size() > 2) begin
        e = q2.pop_front();
        chk("R2 R5 R6 data d2", dout2, e);
      end
    end else begin
      chk("R4 hold data d8", dout8, last8);
      chk("R4 hold data d2", dout2, last2);
      chk("R4 hold valid d8", {7'd0, val8}, {7'd0, lastv8});
      chk("R4 hold valid d2", {7'd0, val2}, {7'd0, lastv2});
    end
    last8 = dout8; last2 = dout2; lastv8 = val8; lastv2 = val2;
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    do_reset();
    step(1'b0, 8'h55);
    for (int i = 0; i < 24; i++) step(1'b1, 8'(8'h10 + i));
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr_next(lfsr);
      step(lfsr[3] | lfsr[7], lfsr[15:8]);
    end
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'hA0 + i));
    do_reset();
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 8'(8'hC0 + i));
      step(1'b0, 8'hFF);
    end
    for (int i = 0; i < 30; i++) step(1'b1, 8'(8'h30 + 3 * i));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule